// File: doc/BRIEF.md
# Sparse Row Run Encoder for a 64-Column Pixel Group

This block takes the thresholded hit bits of one 64-column group of a pixel row and turns them into a short list of run descriptors. A run is a stretch of neighbouring columns that are all hit. Each descriptor gives the column where the run starts and how many pixels it covers, and no descriptor covers more than four pixels. A longer stretch is cut into four-pixel pieces in column order, and the last piece holds what is left. Only the first six descriptors of a row are kept. Hits past that point are dropped, and the count tells the consumer how many descriptor slots hold data.

A row is loaded with a one-cycle `in_valid` strobe, which also captures the group's bank address. A controller built from three named states then runs. In `S_IDLE` it waits for a row and moves to `S_SCAN` when a row arrives. `S_SCAN` lasts exactly `MAX_STATES` cycles. In each of those cycles it extracts the lowest remaining run, as long as hits remain and the list is not full, and after the last scan cycle it moves to `S_EMIT`. In `S_EMIT` it copies the results to the output registers, raises `out_valid` for one cycle and returns to `S_IDLE`. Because the latency is fixed, each row takes exactly eight cycles. That fits comfortably inside a row period of the readout.

Top module: `sds_group_encoder`

## Requirements
- R1: While `rst` is high and after it is released, `out_valid`, `out_count`, `out_bank` and `out_states` are all zero until the first row completes.
- R2: A row sampled with `in_valid` high in idle at clock edge n produces `out_valid` high after edge n+7, for exactly one cycle.
- R3: Descriptor slot i occupies `out_states[8i+7:8i]`. Bits [7:2] hold the run's first column within the group (0..63), and bits [1:0] hold the run length minus one, so code 0 is one pixel and code 3 is four pixels.
- R4: Descriptors are filled from slot 0 upward in ascending column order. The scan always takes the lowest remaining hit column first.
- R5: A run longer than four pixels becomes consecutive four-pixel descriptors followed by one descriptor for the remainder.
- R6: At most six descriptors are produced per row, and hits beyond the sixth descriptor are dropped.
- R7: `out_count` equals the number of descriptors, and every slot at or above `out_count` reads zero.
- R8: `out_bank` presents the bank address that was sampled together with the row.
- R9: `in_valid` pulses that arrive in the seven cycles after a row is accepted are ignored. They produce no extra `out_valid` and do not alter the pending result.
- R10: All outputs hold their values between `out_valid` strobes.
- R11: A run that reaches column 63 ends at the group edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Row load strobe |
| in_hits | input | 64 | Hit bit per column of the group, bit 0 is the lowest column |
| in_bank | input | 5 | Group bank address for this row |
| out_valid | output | 1 | One-cycle result strobe |
| out_states | output | 48 | Six descriptor slots of 8 bits |
| out_count | output | 3 | Number of valid descriptors |
| out_bank | output | 5 | Bank address of the reported row |

## Verification
The bench drives stretches of five or more pixels, which catch a design that emits a single descriptor with a truncated or wrapped length, or that forgets to advance past the first four pixels. Rows carrying more than six runs catch a counter that wraps past six or writes beyond the last slot. A run that touches column 63 exposes a shift that wraps around or that reads past the group edge. An `in_valid` pulse sent while a row is still being processed catches a controller that restarts and either loses the first row or emits a second strobe. A mask that is cleared wrongly between scan steps shows up as descriptors out of order or repeated.

// File: rtl/sds_pkg.sv
package sds_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SCAN = 2'd1,
        S_EMIT = 2'd2
    } sds_state_e;
endpackage

// File: rtl/sds_lowest_hit.sv
module sds_lowest_hit #(
    parameter int W   = 64,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        found = |vec;
    end
endmodule

// File: rtl/sds_run_finder.sv
module sds_run_finder #(
    parameter int W     = 64,
    parameter int LEN_W = 2,
    localparam int IW   = $clog2(W),
    localparam int RUN_MAX = 1 << LEN_W
) (
    input  logic [W-1:0]     mask,
    output logic             found,
    output logic [IW-1:0]    first,
    output logic [LEN_W-1:0] code,
    output logic [W-1:0]     remain
);
    logic [W-1:0] aligned;
    logic [W-1:0] run_bits;
    logic         cont;

    sds_lowest_hit #(.W(W)) u_low (
        .vec  (mask),
        .found(found),
        .idx  (first)
    );

    always_comb begin
        aligned = mask >> first;
        code    = '0;
        cont    = 1'b1;
        for (int k = 1; k < RUN_MAX; k++) begin
            if (cont && aligned[k]) code = LEN_W'(k);
            else                    cont = 1'b0;
        end
        run_bits = ((W'(1) << (int'(code) + 1)) - W'(1)) << first;
        remain   = mask & ~run_bits;
    end
endmodule

// File: rtl/sds_group_encoder.sv
module sds_group_encoder
    import sds_pkg::*;
#(
    parameter int GROUP_W    = 64,
    parameter int MAX_STATES = 6,
    parameter int BANK_W     = 5,
    parameter int LEN_W      = 2,
    localparam int COL_W     = $clog2(GROUP_W),
    localparam int STATE_W   = COL_W + LEN_W,
    localparam int CNT_W     = $clog2(MAX_STATES + 1),
    localparam int STEP_W    = (MAX_STATES > 1) ? $clog2(MAX_STATES) : 1,
    localparam int OUT_W     = MAX_STATES * STATE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [GROUP_W-1:0]  in_hits,
    input  logic [BANK_W-1:0]   in_bank,
    output logic                out_valid,
    output logic [OUT_W-1:0]    out_states,
    output logic [CNT_W-1:0]    out_count,
    output logic [BANK_W-1:0]   out_bank
);
    sds_state_e state, state_nx;

    logic [GROUP_W-1:0] work_mask;
    logic [OUT_W-1:0]   work_states;
    logic [CNT_W-1:0]   work_cnt;
    logic [BANK_W-1:0]  work_bank;
    logic [STEP_W-1:0]  step;

    logic               f_found;
    logic [COL_W-1:0]   f_first;
    logic [LEN_W-1:0]   f_code;
    logic [GROUP_W-1:0] f_remain;
    logic               take;

    sds_run_finder #(.W(GROUP_W), .LEN_W(LEN_W)) u_find (
        .mask  (work_mask),
        .found (f_found),
        .first (f_first),
        .code  (f_code),
        .remain(f_remain)
    );

    assign take = f_found && (work_cnt < CNT_W'(MAX_STATES));

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (in_valid) state_nx = S_SCAN;
            S_SCAN:  if (step == STEP_W'(MAX_STATES - 1)) state_nx = S_EMIT;
            S_EMIT:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            work_mask   <= '0;
            work_states <= '0;
            work_cnt    <= '0;
            work_bank   <= '0;
            step        <= '0;
            out_valid   <= 1'b0;
            out_states  <= '0;
            out_count   <= '0;
            out_bank    <= '0;
        end else begin
            out_valid <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (in_valid) begin
                        work_mask   <= in_hits;
                        work_bank   <= in_bank;
                        work_states <= '0;
                        work_cnt    <= '0;
                        step        <= '0;
                    end
                end
                S_SCAN: begin
                    step <= step + STEP_W'(1);
                    if (take) begin
                        work_states[int'(work_cnt) * STATE_W +: STATE_W] <= {f_first, f_code};
                        work_cnt  <= work_cnt + CNT_W'(1);
                        work_mask <= f_remain;
                    end
                end
                S_EMIT: begin
                    out_valid  <= 1'b1;
                    out_states <= work_states;
                    out_count  <= work_cnt;
                    out_bank   <= work_bank;
                end
                default: ;
            endcase
        end
    end

    // R6
    cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
        work_cnt <= CNT_W'(MAX_STATES));

    // R2
    out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R10
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
        (state != S_EMIT) |=> ($stable(out_count) && $stable(out_bank) && $stable(out_states)));

    // R4
    lowest_first_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_SCAN && f_found) |-> (work_mask[f_first] &&
            ((work_mask & ((GROUP_W'(1) << f_first) - GROUP_W'(1))) == '0)));

    // R7
    empty_slots_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_states >> (int'(out_count) * STATE_W)) == '0));

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_SCAN && in_valid) |=> $stable(work_bank));
endmodule

// File: tb/sds_group_encoder_bench.sv
module sds_group_encoder_bench;
    localparam int GW = 64;
    localparam int MS = 6;
    localparam int BW = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [GW-1:0] in_hits = '0;
    logic [BW-1:0] in_bank = '0;
    logic          out_valid;
    logic [47:0]   out_states;
    logic [2:0]    out_count;
    logic [BW-1:0] out_bank;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    always #10 clk = ~clk;

    sds_group_encoder u_sds_group_encoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_hits(in_hits),
        .in_bank(in_bank), .out_valid(out_valid), .out_states(out_states),
        .out_count(out_count), .out_bank(out_bank)
    );

    // behavioural reference of the run encoding (R3 R4 R5 R6 R11)
    function automatic void encode(input logic [GW-1:0] h,
                                   output logic [47:0] st, output int cnt);
        int c;
        st = '0; cnt = 0; c = 0;
        while (c < GW && cnt < MS) begin
            if (h[c]) begin
                int len;
                len = 0;
                while (c + len < GW && len < 4 && h[c + len]) len++;
                st[cnt*8 +: 8] = {c[5:0], 2'(len - 1)};
                cnt++;
                c += len;
            end else begin
                c++;
            end
        end
    endfunction

    // cycle model: busy phase counter, results published on the 8th edge
    int          phase = 0;
    logic [47:0] pend_st;
    int          pend_cnt;
    logic [BW-1:0] pend_bank;
    logic        exp_valid = 0;
    logic [47:0] exp_st = '0;
    int          exp_cnt = 0;
    logic [BW-1:0] exp_bank = '0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            phase <= 0; exp_valid <= 0; exp_st <= '0; exp_cnt <= 0; exp_bank <= '0;
        end else begin
            exp_valid <= 0;
            if (phase == 0) begin
                if (in_valid) begin
                    logic [47:0] s; int n;
                    encode(in_hits, s, n);
                    pend_st <= s; pend_cnt <= n; pend_bank <= in_bank;
                    phase <= 1;
                end
            end else if (phase == 7) begin
                exp_valid <= 1; exp_st <= pend_st; exp_cnt <= pend_cnt;
                exp_bank <= pend_bank; phase <= 0;
            end else begin
                phase <= phase + 1;
            end
        end
    end

    // compare every cycle away from the active edge (R2 R3 R7 R8 R10)
    always @(negedge clk) begin
        if (!rst) begin
            vectors++;
            if (out_valid !== exp_valid) begin
                errors++; $display("FAIL R2 out_valid act=%0b exp=%0b", out_valid, exp_valid);
            end
            if (out_count !== 3'(exp_cnt)) begin
                errors++; $display("FAIL R7 out_count act=%0d exp=%0d", out_count, exp_cnt);
            end
            if (out_bank !== exp_bank) begin
                errors++; $display("FAIL R8 out_bank act=%0d exp=%0d", out_bank, exp_bank);
            end
            if (out_states !== exp_st) begin
                errors++; $display("FAIL R3 out_states act=%h exp=%h", out_states, exp_st);
            end
        end
    end

    task automatic row(input logic [GW-1:0] h, input logic [BW-1:0] b);
        @(negedge clk); in_valid = 1; in_hits = h; in_bank = b;
        @(negedge clk); in_valid = 0; in_hits = '0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        vectors++;
        if (out_valid !== 0 || out_count !== 0 || out_states !== '0 || out_bank !== 0) begin
            errors++; $display("FAIL R1 reset outputs act=%0b/%0d/%h exp=0", out_valid, out_count, out_states);
        end
        rst = 0;
        repeat (2) @(negedge clk);
        row(64'h0, 5'd1);                         // empty row, R7
        row(64'h1, 5'd2);                         // single at column 0, R3
        row(64'h0000_0000_0000_F0F0, 5'd3);       // two runs of four, R4
        row(64'h0000_0000_0003_FF00, 5'd4);       // run of ten, R5
        row(64'h0000_0000_0000_5555, 5'd5);       // eight singles, cap R6
        row(64'hFFFF_FFFF_FFFF_FFFF, 5'd6);       // full row, R5 R6
        row(64'hE000_0000_0000_0000, 5'd7);       // run at group edge, R11
        row(64'h8000_0000_0000_0001, 5'd8);       // both edges, R11
        row(64'h00F0_0000_1C00_0062, 5'd9);       // mixed lengths, R4
        // R9: in_valid while busy must be ignored
        @(negedge clk); in_valid = 1; in_hits = 64'h0F; in_bank = 5'd10;
        @(negedge clk); in_hits = 64'hFF00; in_bank = 5'd11;
        repeat (3) @(negedge clk);
        in_valid = 0; in_hits = '0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < 25; i++) begin
            logic [GW-1:0] r;
            r = {$urandom, $urandom} & {$urandom, $urandom};
            row(r, 5'($urandom));
        end
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        errors++;
        $display("FAIL watchdog act=%0d exp<20000 cycles", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule